// File: doc/BRIEF.md
# Six-bit BCD Character Parity and Digit Validity Checker

This block protects characters held in a six-bit binary-coded-decimal format, where each character has two zone bits, four numeric bits, an odd-parity check bit and a word-mark flag. It works in one of two modes. In generate mode it computes the check bit that gives the character an odd number of set bits, and the word mark counts toward that total. In check mode it passes each character through unchanged and flags any character whose eight bits have an even population.

The same block can also check the numeric bits. When this check is enabled, it flags any numeric code that is not a legal digit. Decimal zero is written as the 8-2 code, so an all-zero numeric field is illegal. The block handles `LANES` characters in parallel and has one register stage. It also keeps a sticky error flag that stays set until software or control logic asserts an explicit clear.

Character bit layout in each lane: bit 7 is the word mark, bit 6 is the check bit, bit 5 is zone B, bit 4 is zone A, and bits 3..0 are the numeric weights 8, 4, 2, 1. Zones B and A together stand for the 12-zone. B alone stands for the 11-zone and A alone for the 0-zone. The checker carries the zone bits through without changing them.

Top module: `bcd_char_checker`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid`, `char_out`, `parity_err`, `validity_err` and `sticky_err` are all zero.
- R2: In generate mode (`mode_check` = 0), each lane of `char_out` equals its input with bit 6 replaced. Bit 6 is 1 exactly when bits 7, 5, 4, 3, 2, 1, 0 hold an even number of ones. `parity_err` stays 0 in this mode.
- R3: The word mark is part of the generated parity. Input 0x27 (B, 4, 2, 1, no word mark) yields 0x67, and input 0xA7 (same bits with word mark) yields 0xA7.
- R4: In check mode (`mode_check` = 1), each lane of `char_out` equals its input unchanged. The lane's `parity_err` bit is 1 exactly when all eight input bits hold an even number of ones.
- R5: With `num_chk_en` = 1, a lane's `validity_err` bit is 1 exactly when its numeric bits 3..0 are 0000 or lie in 1011..1111. The codes 0001..1001 (digits 1 to 9) and 1010 (digit zero) are legal. This check applies in both modes.
- R6: With `num_chk_en` = 0, `validity_err` is 0 for every numeric code.
- R7: Outputs appear one clock after `in_valid`. `out_valid` is `in_valid` delayed by one cycle. After a cycle with `in_valid` low, both error vectors are 0 and `char_out` keeps its previous value.
- R8: `sticky_err` is set on the same edge that any lane's `parity_err` or `validity_err` is registered as 1. It then stays set until a clock with `err_clr` high clears it. If a new error arrives in the same cycle as `err_clr`, the flag stays set.
- R9: Lanes are independent. Each lane's outputs depend only on that lane's input character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input characters present this cycle |
| mode_check | input | 1 | 0 = generate check bit, 1 = check odd parity |
| num_chk_en | input | 1 | Enables the numeric digit legality check |
| err_clr | input | 1 | Clears the sticky error flag |
| char_in | input | 8*LANES | Input characters, lane 0 in bits 7..0 |
| out_valid | output | 1 | Registered result valid |
| char_out | output | 8*LANES | Registered characters (check bit regenerated or passed) |
| parity_err | output | LANES | Per-lane even-parity error |
| validity_err | output | LANES | Per-lane illegal numeric code |
| sticky_err | output | 1 | Latched OR of all errors until cleared |

## Verification
The bench builds the checker with `LANES` = 2. It sweeps all 256 codes on lane 0 in every combination of mode and numeric enable. Lane 1 carries a scrambled copy of the same code, so every parity class, every numeric code and every word-mark and check-bit pairing is reached in both lanes with differing values side by side. Directed steps then cover idle holding, the fixed word-mark examples, and the clear-versus-new-error collision on the sticky flag.

// File: rtl/bcd_chk_pkg.sv
package bcd_chk_pkg;

    localparam int CHAR_W = 8;
    localparam int NUM_W  = 4;

    // Bit layout of one stored character
    typedef struct packed {
        logic             wm;      // word mark
        logic             chk;     // odd-parity check bit
        logic             zone_b;
        logic             zone_a;
        logic [NUM_W-1:0] num;     // 8-4-2-1 weights
    } bcd_char_t;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } chk_mode_e;

    typedef struct packed {
        logic perr;
        logic verr;
    } lane_flags_t;

    // Highest legal numeric code: 8-2 encodes decimal zero
    localparam logic [NUM_W-1:0] NUM_TOP_LEGAL = 4'b1010;

    // Check bit that makes the whole character odd
    function automatic logic gen_check_bit(input bcd_char_t c);
        return ~(c.wm ^ c.zone_b ^ c.zone_a ^ (^c.num));
    endfunction

    // True when the full eight bits hold an even count
    function automatic logic is_even_char(input bcd_char_t c);
        return ~(^c);
    endfunction

    function automatic logic digit_is_legal(input logic [NUM_W-1:0] n);
        return (n != '0) && (n <= NUM_TOP_LEGAL);
    endfunction

endpackage

// File: rtl/bcd_parity_unit.sv
module bcd_parity_unit
    import bcd_chk_pkg::*;
(
    input  bcd_char_t ch_i,
    input  chk_mode_e mode_i,
    output bcd_char_t ch_o,
    output logic      perr_o
);

    always_comb begin
        ch_o   = ch_i;
        perr_o = 1'b0;
        unique case (mode_i)
            MODE_GEN: ch_o.chk = gen_check_bit(ch_i);
            MODE_CHK: perr_o   = is_even_char(ch_i);
            default:  perr_o   = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcd_digit_checker.sv
module bcd_digit_checker
    import bcd_chk_pkg::*;
(
    input  logic [NUM_W-1:0] num_i,
    input  logic             en_i,
    output logic             verr_o
);

    always_comb begin
        verr_o = en_i && !digit_is_legal(num_i);
    end

endmodule

// File: rtl/bcd_lane.sv
module bcd_lane
    import bcd_chk_pkg::*;
(
    input  logic [CHAR_W-1:0] char_i,
    input  chk_mode_e         mode_i,
    input  logic              num_en_i,
    output logic [CHAR_W-1:0] char_o,
    output lane_flags_t       flags_o
);

    bcd_char_t ch_in;
    bcd_char_t ch_out;
    logic      perr;
    logic      verr;

    assign ch_in = bcd_char_t'(char_i);

    bcd_parity_unit u_par (
        .ch_i   (ch_in),
        .mode_i (mode_i),
        .ch_o   (ch_out),
        .perr_o (perr)
    );

    bcd_digit_checker u_dig (
        .num_i  (ch_in.num),
        .en_i   (num_en_i),
        .verr_o (verr)
    );

    assign char_o       = ch_out;
    assign flags_o.perr = perr;
    assign flags_o.verr = verr;

endmodule

// File: rtl/bcd_char_checker.sv
module bcd_char_checker
    import bcd_chk_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    mode_check,
    input  logic                    num_chk_en,
    input  logic                    err_clr,
    input  logic [LANES*CHAR_W-1:0] char_in,
    output logic                    out_valid,
    output logic [LANES*CHAR_W-1:0] char_out,
    output logic [LANES-1:0]        parity_err,
    output logic [LANES-1:0]        validity_err,
    output logic                    sticky_err
);

    localparam int BUS_W = LANES * CHAR_W;

    chk_mode_e         mode;
    logic [BUS_W-1:0]  char_c;
    logic [LANES-1:0]  perr_c;
    logic [LANES-1:0]  verr_c;
    logic              any_err_c;

    assign mode = chk_mode_e'(mode_check);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_flags_t flags;

        bcd_lane u_lane (
            .char_i   (char_in[g*CHAR_W +: CHAR_W]),
            .mode_i   (mode),
            .num_en_i (num_chk_en),
            .char_o   (char_c[g*CHAR_W +: CHAR_W]),
            .flags_o  (flags)
        );

        assign perr_c[g] = flags.perr;
        assign verr_c[g] = flags.verr;
    end

    assign any_err_c = in_valid && ((|perr_c) || (|verr_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            char_out     <= '0;
            parity_err   <= '0;
            validity_err <= '0;
            sticky_err   <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            if (in_valid) begin
                char_out <= char_c;
            end
            parity_err   <= in_valid ? perr_c : '0;
            validity_err <= in_valid ? verr_c : '0;
            sticky_err   <= any_err_c || (sticky_err && !err_clr);
        end
    end

endmodule

// File: rtl/bcd_char_checker_sva.sv
module bcd_char_checker_sva
    import bcd_chk_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    mode_check,
    input logic                    num_chk_en,
    input logic                    err_clr,
    input logic [LANES*CHAR_W-1:0] char_in,
    input logic                    out_valid,
    input logic [LANES*CHAR_W-1:0] char_out,
    input logic [LANES-1:0]        parity_err,
    input logic [LANES-1:0]        validity_err,
    input logic                    sticky_err
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);  // R7
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);  // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (parity_err == '0 && validity_err == '0));  // R7
    AST_GEN_NO_PERR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_check) |=> parity_err == '0);  // R2
    AST_CHK_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_check) |=> char_out == $past(char_in));  // R4
    AST_NUM_OFF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !num_chk_en) |=> validity_err == '0);  // R6
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ((|parity_err) || (|validity_err))) |-> sticky_err);  // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sticky_err && !err_clr) |=> sticky_err);  // R8

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        AST_GEN_ODD: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !mode_check) |=>
                ($countones(char_out[g*CHAR_W +: CHAR_W]) % 2 == 1));  // R2
    end

endmodule

bind bcd_char_checker bcd_char_checker_sva #(.LANES(LANES)) u_sva (.*);

// File: tb/bcd_char_checker_test.sv
`timescale 1ns/1ps
module bcd_char_checker_test;

    localparam int LANES = 2;
    localparam int W     = LANES * 8;

    logic           clk = 1'b0;
    logic           rst;
    logic           in_valid;
    logic           mode_check;
    logic           num_chk_en;
    logic           err_clr;
    logic [W-1:0]   char_in;
    logic           out_valid;
    logic [W-1:0]   char_out;
    logic [LANES-1:0] parity_err;
    logic [LANES-1:0] validity_err;
    logic           sticky_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic exp_sticky;

    always #10 clk = ~clk;

    bcd_char_checker #(.LANES(LANES)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_check(mode_check),
        .num_chk_en(num_chk_en), .err_clr(err_clr), .char_in(char_in),
        .out_valid(out_valid), .char_out(char_out), .parity_err(parity_err),
        .validity_err(validity_err), .sticky_err(sticky_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_char(input logic [7:0] c, input logic m);
        logic [7:0] r;
        int n;
        r = c;
        if (!m) begin
            n = $countones({c[7], c[5:0]});
            r[6] = (n % 2 == 0);
        end
        return r;
    endfunction

    function automatic logic exp_perr(input logic [7:0] c, input logic m);
        return m && ($countones(c) % 2 == 0);
    endfunction

    function automatic logic exp_verr(input logic [7:0] c, input logic en);
        return en && ((c[3:0] == 4'd0) || (c[3:0] > 4'd10));
    endfunction

    // Apply one vector, then check results one clock later
    task automatic apply(input logic [7:0] c0, input logic [7:0] c1,
                         input logic m, input logic en, input logic clr);
        logic [LANES-1:0] pe, ve;
        @(negedge clk);
        in_valid = 1'b1; mode_check = m; num_chk_en = en; err_clr = clr;
        char_in = {c1, c0};
        @(negedge clk);
        in_valid = 1'b0; err_clr = 1'b0;
        pe = {exp_perr(c1, m), exp_perr(c0, m)};
        ve = {exp_verr(c1, en), exp_verr(c0, en)};
        exp_sticky = (|pe) || (|ve) || (exp_sticky && !clr);
        check("R7 out_valid", 32'(out_valid), 32'd1);
        check(m ? "R4 char lane0" : "R2 char lane0", 32'(char_out[7:0]), 32'(exp_char(c0, m)));
        check("R9 char lane1", 32'(char_out[15:8]), 32'(exp_char(c1, m)));
        check(m ? "R4 parity_err" : "R2 parity_err", 32'(parity_err), 32'(pe));
        check(en ? "R5 validity_err" : "R6 validity_err", 32'(validity_err), 32'(ve));
        check("R8 sticky_err", 32'(sticky_err), 32'(exp_sticky));
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; mode_check = 1'b0; num_chk_en = 1'b0;
        err_clr = 1'b0; char_in = '0; exp_sticky = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 char_out", 32'(char_out), 32'd0);
        check("R1 errors", 32'({parity_err, validity_err}), 32'd0);
        check("R1 sticky", 32'(sticky_err), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", 32'({out_valid, sticky_err}), 32'd0);

        // R3 word-mark examples
        apply(8'h27, 8'hA7, 1'b0, 1'b0, 1'b0);
        check("R3 no word mark", 32'(char_out[7:0]), 32'h67);
        check("R3 with word mark", 32'(char_out[15:8]), 32'hA7);

        // Exhaustive sweep over modes, enable, and all codes
        for (int m = 0; m < 2; m++) begin
            for (int en = 0; en < 2; en++) begin
                for (int c = 0; c < 256; c++) begin
                    logic [7:0] c0, c1;
                    c0 = 8'(c);
                    c1 = 8'(c) ^ 8'hA5;
                    apply(c0, c1, m[0], en[0], (c % 17) == 0);
                end
            end
        end

        // R7 idle: outputs quiet, char_out held
        apply(8'h41, 8'h02, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        check("R7 idle out_valid", 32'(out_valid), 32'd0);
        check("R7 idle errors", 32'({parity_err, validity_err}), 32'd0);
        check("R7 idle hold", 32'(char_out), 32'h0241);

        // R8 sticky clear with no new error
        apply(8'h01, 8'h01, 1'b0, 1'b1, 1'b1);
        check("R8 cleared", 32'(sticky_err), 32'd0);
        // R8 sticky set then held across idle cycles
        apply(8'h00, 8'h01, 1'b0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        check("R8 held", 32'(sticky_err), 32'd1);
        // R8 clear collides with a new error: stays set
        apply(8'h01, 8'h0F, 1'b0, 1'b1, 1'b1);
        check("R8 set wins", 32'(sticky_err), 32'd1);
        apply(8'h01, 8'h0A, 1'b0, 1'b1, 1'b1);
        check("R8 final clear", 32'(sticky_err), 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule